// File: doc/BRIEF.md
# Special-Function Register Overlay for a Memory Port

This block sits between one access port of a dual-port memory and the memory array. It uses the port's own pins: chip enable, read/write, output enable, two byte selects, address and data. A separate special-function enable turns two fixed low addresses into register accesses. When the enable is active, a read of address 0 returns the synchronized state of a small group of external input pins. A write to address 1 loads a latched output register whose bits drive external output pins. All other accesses, and every access made while the enable is inactive, go through unchanged to the array over the memory-side signals.

The host side is sampled by a clock. Memory-side control, the read-data multiplexer and the data-drive enable are combinational from the host pins. The output register and the input synchronizer are the only state. A parameter removes the input-register read path. In that variant a special-function read of address 0 is an ordinary memory read.

Top module: `sfio_port`

## Requirements
- R1: With `sf_en` low, any access with `ce_n` low and at least one byte select low reaches the array. `mem_en` is 1, `mem_we` equals `!rw`, and `mem_addr`, `mem_wdata` and `mem_be` (bit 1 = upper byte, bit 0 = lower byte, active high) follow the host pins. `rdata` equals `mem_rdata`.
- R2: With `HAS_IN`=1, a special-function read of address 0 returns the synchronized inputs on `rdata[1:0]` and zeros on every higher bit. This read needs `sf_en`=1, `ce_n`=0, `rw`=1, `oe_n`=0 and `lb_n`=0. `mem_en` is 0 during it.
- R3: During that read the upper byte select has no effect. With `lb_n`=1 the access is an ordinary memory read of address 0 instead.
- R4: A write with `sf_en`=1, `ce_n`=0, `rw`=0 at address 1 loads `wdata[4:0]` into the output register at that clock edge. Both byte selects are ignored. The new value shows on `ext_out` once the edge has passed.
- R5: `ext_out` resets to all zeros and keeps its value across every clock edge that is not an R4 write.
- R6: A write with `sf_en`=1 at address 0 or 1 never asserts `mem_we`, so the array words at those addresses are left as they were.
- R7: `ext_in` passes through two flops. A change made between edges shows on a register read after the second following edge and not after the first.
- R8: With `HAS_IN`=0, the R2 access is an ordinary memory read: `mem_en`=1 and `rdata` equals `mem_rdata`.
- R9: `rdata_oe` is 1 exactly when `ce_n`=0, `rw`=1 and `oe_n`=0. With `ce_n`=1, or with both byte selects high, `mem_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sf_en | input | 1 | Special-function enable, active high |
| ce_n | input | 1 | Chip enable, active low |
| rw | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte select, active low |
| lb_n | input | 1 | Lower byte select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data from host |
| rdata | output | DATA_W | Read data to host |
| rdata_oe | output | 1 | Host data bus drive enable |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array write enable |
| mem_be | output | 2 | Array byte enables, active high |
| mem_addr | output | ADDR_W | Array address |
| mem_wdata | output | DATA_W | Array write data |
| mem_rdata | input | DATA_W | Array read data |
| ext_in | input | IN_W | External input pins, asynchronous |
| ext_out | output | OUT_W | External output pins |

## Verification
The assertions assume that the host pins stay stable around each sampling clock edge. They also need reset to be held for at least one edge before the first access. The bench changes every host input only at the falling edge and releases reset only after several cycles. It drives `ext_in` only between edges, so the check that the input pins arrive two edges later sees a clean sample. The bench's memory model writes only at rising edges, which keeps array contents consistent with what the block sees on its memory side.

// File: rtl/sfio_pkg.sv
package sfio_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_MEM    = 2'd1,
    ACC_IN_RD  = 2'd2,
    ACC_OUT_WR = 2'd3
  } acc_e;

  // Classify one host access from the pin levels.
  function automatic acc_e classify(
    input logic has_in,
    input logic sf_en,
    input logic ce_n,
    input logic rw,
    input logic oe_n,
    input logic ub_n,
    input logic lb_n,
    input logic at0,
    input logic at1
  );
    if (ce_n)                                             return ACC_IDLE;
    else if (has_in && sf_en && rw && !oe_n && !lb_n && at0) return ACC_IN_RD;
    else if (sf_en && !rw && at1)                         return ACC_OUT_WR;
    else if (sf_en && !rw && at0)                         return ACC_IDLE;
    else if (ub_n && lb_n)                                return ACC_IDLE;
    else                                                  return ACC_MEM;
  endfunction

  // Place the synchronized inputs in the low bits of a data word.
  function automatic logic [63:0] pack_inputs(input logic [63:0] v, input int unsigned w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) if (i < int'(w)) r[i] = v[i];
    return r;
  endfunction

endpackage

// File: rtl/sfio_decode.sv
module sfio_decode
  import sfio_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter bit HAS_IN = 1'b1
) (
  input  logic              sf_en,
  input  logic              ce_n,
  input  logic              rw,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc
);
  localparam logic [ADDR_W-1:0] IN_ADDR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OUT_ADDR = ADDR_W'(1);

  logic at0, at1;
  assign at0 = (addr == IN_ADDR);
  assign at1 = (addr == OUT_ADDR);

  always_comb acc = classify(HAS_IN, sf_en, ce_n, rw, oe_n, ub_n, lb_n, at0, at1);
endmodule

// File: rtl/sfio_in_sync.sv
module sfio_in_sync #(
  parameter int IN_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] async_in,
  output logic [IN_W-1:0] sync_q
);
  logic [IN_W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      sync_q <= '0;
    end else begin
      stage1 <= async_in;
      sync_q <= stage1;
    end
  end

  // Edges seen since reset, saturating at 2, for the checker below.
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r7_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (sync_q == $past(async_in, 2)));
endmodule

// File: rtl/sfio_out_reg.sv
module sfio_out_reg #(
  parameter int OUT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] din,
  output logic [OUT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(din)));
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/sfio_port.sv
module sfio_port
  import sfio_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int IN_W   = 2,
  parameter int OUT_W  = 5,
  parameter bit HAS_IN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sf_en,
  input  logic              ce_n,
  input  logic              rw,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              mem_en,
  output logic              mem_we,
  output logic [1:0]        mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [IN_W-1:0]   ext_in,
  output logic [OUT_W-1:0]  ext_out
);
  localparam int BYTES = DATA_W / 8;

  initial begin
    if (BYTES != 2)      $error("sfio_port: DATA_W must be 16");
    if (OUT_W > DATA_W)  $error("sfio_port: OUT_W wider than data");
    if (IN_W > DATA_W)   $error("sfio_port: IN_W wider than data");
  end

  acc_e             acc;
  logic [IN_W-1:0]  in_sync;
  logic             out_load;
  logic [DATA_W-1:0] in_word;

  sfio_decode #(.ADDR_W(ADDR_W), .HAS_IN(HAS_IN)) u_dec (
    .sf_en(sf_en), .ce_n(ce_n), .rw(rw), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .acc(acc)
  );

  sfio_in_sync #(.IN_W(IN_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_in), .sync_q(in_sync)
  );

  assign out_load = (acc == ACC_OUT_WR);

  sfio_out_reg #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(out_load),
    .din(wdata[OUT_W-1:0]), .q(ext_out)
  );

  assign in_word   = DATA_W'(pack_inputs(64'(in_sync), IN_W));
  assign mem_en    = (acc == ACC_MEM);
  assign mem_we    = mem_en && !rw;
  assign mem_be    = {!ub_n, !lb_n};
  assign mem_addr  = addr;
  assign mem_wdata = wdata;
  assign rdata     = (acc == ACC_IN_RD) ? in_word : mem_rdata;
  assign rdata_oe  = !ce_n && rw && !oe_n;

  a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_en |-> (mem_en == (!ce_n && !(ub_n && lb_n))));
  a_r2_no_mem_on_reg_read: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_IN && sf_en && !ce_n && rw && !oe_n && !lb_n && addr == '0) |-> !mem_en);
  a_r6_no_mem_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_en && !ce_n && !rw && addr < ADDR_W'(2)) |-> !mem_we);
  a_r9_drive: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!ce_n && rw));
endmodule

// File: tb/sim_sfio_port.sv
module sim_sfio_port;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic sf_en = 0, ce_n = 1, rw = 1, oe_n = 1, ub_n = 1, lb_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0] ext_in = '0;

  logic [DW-1:0] rdata, mem_wdata, mem_rdata;
  logic rdata_oe, mem_en, mem_we;
  logic [1:0] mem_be;
  logic [AW-1:0] mem_addr;
  logic [4:0] ext_out;

  logic [DW-1:0] rdata1, mem_wdata1;
  logic rdata_oe1, mem_en1, mem_we1;
  logic [1:0] mem_be1;
  logic [AW-1:0] mem_addr1;
  logic [4:0] ext_out1;
  localparam logic [DW-1:0] U1_RD = 16'hC3A5;

  sfio_port u0 (
    .clk(clk), .rst_n(rst_n), .sf_en(sf_en), .ce_n(ce_n), .rw(rw), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe), .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ext_in(ext_in), .ext_out(ext_out)
  );

  sfio_port #(.HAS_IN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sf_en(sf_en), .ce_n(ce_n), .rw(rw), .oe_n(oe_n),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .rdata(rdata1),
    .rdata_oe(rdata_oe1), .mem_en(mem_en1), .mem_we(mem_we1), .mem_be(mem_be1),
    .mem_addr(mem_addr1), .mem_wdata(mem_wdata1), .mem_rdata(U1_RD),
    .ext_in(ext_in), .ext_out(ext_out1)
  );

  // Memory model on u0's memory side.
  logic [DW-1:0] mem [NW];
  initial for (int i = 0; i < NW; i++) mem[i] = '0;
  always @(posedge clk) if (mem_en && mem_we) begin
    if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
    if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
  end
  assign mem_rdata = mem[mem_addr];

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 257) ^ 16'h5A3C;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, settle, then the caller checks.
  task automatic put(input logic s, input logic c, input logic r, input logic o,
                     input logic u, input logic l, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    sf_en = s; ce_n = c; rw = r; oe_n = o; ub_n = u; lb_n = l;
    addr = AW'(a); wdata = d;
    #1;
  endtask

  task automatic idle();
    put(0, 1, 1, 1, 1, 1, 0, '0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] prev_in;
    logic [DW-1:0] exp_w;
    repeat (3) @(negedge clk);
    #1;
    chk("R5 reset ext_out", 32'(ext_out), 0);
    chk("R9 idle oe", 32'(rdata_oe), 0);
    chk("R9 idle mem_en", 32'(mem_en), 0);
    @(negedge clk);
    rst_n = 1;

    // R1: plain writes over every address, then plain reads.
    for (int a = 0; a < NW; a++) begin
      put(0, 0, 0, 1, 0, 0, a, pat(a));
      if (a == 1) begin
        chk("R1 mem_en", 32'(mem_en), 1);
        chk("R1 mem_we", 32'(mem_we), 1);
        chk("R1 mem_be", 32'(mem_be), 3);
        chk("R1 mem_wdata", 32'(mem_wdata), 32'(pat(1)));
      end
    end
    idle();
    for (int a = 0; a < NW; a++) begin
      put(0, 0, 1, 0, 0, 0, a, '0);
      chk("R1 read back", 32'(rdata), 32'(pat(a)));
      if (a == 0) chk("R9 read oe", 32'(rdata_oe), 1);
    end
    // Byte select: lower byte only.
    put(0, 0, 0, 1, 1, 0, 5, 16'hFFFF);
    chk("R1 be lower only", 32'(mem_be), 1);
    idle();
    put(0, 0, 1, 0, 0, 0, 5, '0);
    chk("R1 partial write", 32'(rdata), 32'({pat(5)[15:8], 8'hFF}));
    put(0, 0, 1, 1, 0, 0, 5, '0);
    chk("R9 oe_n high", 32'(rdata_oe), 0);
    put(0, 0, 0, 1, 1, 1, 6, 16'h0);
    chk("R9 no byte select", 32'(mem_en), 0);
    put(0, 1, 0, 1, 0, 0, 6, 16'h0);
    chk("R9 ce high", 32'(mem_en), 0);

    // R6 and R4: register writes leave array words alone.
    put(1, 0, 0, 1, 0, 0, 0, 16'h1234);
    chk("R6 addr0 mem_we", 32'(mem_we), 0);
    put(1, 0, 0, 1, 0, 0, 1, 16'h1234);
    chk("R6 addr1 mem_we", 32'(mem_we), 0);
    idle();
    chk("R4 load", 32'(ext_out), 32'h14);
    put(0, 0, 1, 0, 0, 0, 0, '0);
    chk("R6 word0 kept", 32'(rdata), 32'(pat(0)));
    put(0, 0, 1, 0, 0, 0, 1, '0);
    chk("R6 word1 kept", 32'(rdata), 32'(pat(1)));

    // R4 sweep of every output value, byte selects varied.
    for (int v = 0; v < 32; v++) begin
      put(1, 0, 0, v[2], v[0], v[1], 1, 16'hFFE0 | DW'(v));
      idle();
      chk("R4 sweep", 32'(ext_out), 32'(v));
    end

    // R5: non-qualifying accesses keep the register.
    put(0, 0, 0, 1, 0, 0, 1, 16'h0000);
    put(1, 0, 1, 0, 0, 0, 1, '0);
    put(1, 0, 0, 1, 0, 0, 2, 16'h0000);
    put(1, 1, 0, 1, 0, 0, 1, 16'h0000);
    idle();
    chk("R5 hold", 32'(ext_out), 31);
    put(0, 0, 0, 1, 0, 0, 1, pat(1));
    idle();

    // R2, R7, R8: input register reads.
    prev_in = ext_in;
    for (int x = 0; x < 4; x++) begin
      logic [1:0] nx;
      nx = 2'(x + 1);
      @(negedge clk); ext_in = nx;
      put(1, 0, 1, 0, x[0], 0, 0, '0);
      chk("R7 one edge old", 32'(rdata), 32'(prev_in));
      put(1, 0, 1, 0, x[0], 0, 0, '0);
      chk("R2 input read", 32'(rdata), 32'(nx));
      chk("R2 no mem", 32'(mem_en), 0);
      chk("R3 ub ignored oe", 32'(rdata_oe), 1);
      chk("R8 fallthrough data", 32'(rdata1), 32'(U1_RD));
      chk("R8 fallthrough en", 32'(mem_en1), 1);
      prev_in = nx;
    end

    // R3: lower byte select high falls to memory.
    put(1, 0, 1, 0, 0, 1, 0, '0);
    exp_w = pat(0);
    chk("R3 lb high mem_en", 32'(mem_en), 1);
    chk("R3 lb high data", 32'(rdata), 32'(exp_w));

    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule